// File: doc/BRIEF.md
# Multiplexed Controller Keypad Scanner

This block reads the keypads of four game controllers through a single shared scan engine. A two-bit port select chooses which controller's keypad and top side button reach the scanner; the block drives one of four row lines at a time, senses the four column lines returned by every port, and folds the first pressed key it finds into a 4-bit key code. Each newly seen key latches that code, and can raise a keyboard interrupt. A combinational translation presents the latched code as a final keypad value. The selected controller's top side button appears as a shift flag and raises a break interrupt on each press.

The bottom side buttons are not routed through the select. Each port has its own active-low trigger output that follows its button after the input synchronisers. Both interrupt requests are sticky until software strobes an acknowledge, and events arriving while their enable bit is low are dropped. A write to the port select restarts the scan and throws away the first full scan that follows, so a key held on the previously selected controller is never reported against the new one.

Top module: `padmux_keyscan`

## Requirements
- R1: Select value 0 routes port 0 (leftmost), 1 port 1, 2 port 2 and 3 port 3 to the keypad scanner and to the shift flag. The select takes effect on the clock edge where `sel_wr` is high.
- R2: `trig_n[p]` is low while `bot_btn[p]` is held, after `SYNC_STAGES` cycles of synchronisation, whatever the select holds.
- R3: `kbcode` carries the latched 4-bit key code in bits 4:1; bits 7:5 and bit 0 read as zero.
- R4: `keypad_val` translates the code: 0 gives 0xFF (no key), 1 gives 0x0B, 2 gives 0x00, 3 gives 0x0A, 4 gives 0x0E, 5 to 7 give 9 to 7, 8 gives 0x0D, 9 to 11 give 6 to 4, 12 gives 0x0C, and 13 to 15 give 3 to 1.
- R5: `shift_flag` follows the selected port's top button. A 0-to-1 change of it sets `irq_brk` when `irq_en[1]` is high, except in the cycle right after a select write.
- R6: A key report sets `irq_key` one cycle after the code latches, when `irq_en[0]` is high. No debounce enable is needed.
- R7: A key is reported once, at the end of the first scan that finds it. It is not reported again while it stays held. A different key seen in a later scan is reported.
- R8: A pending interrupt stays high until its bit of `irq_ack` is strobed. An event with its enable bit low sets nothing. The key code still latches in that case.
- R9: A select write returns the scan to row 0 on the next cycle and discards the result of the first complete scan after it.
- R10: `row_drive` is one-hot (bit r drives row r) and each row lasts `DWELL` cycles, in the order 0,1,2,3. The key at row r, column c has code 4r+c. Row 0 column 0 is not a key. When several keys are down, the lowest code wins.
- R11: After reset, `kbcode` is 0, `keypad_val` is 0xFF, both interrupts are low and `row_drive` is 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Strobe that loads the port select |
| sel_data | input | 2 | New port select value |
| row_drive | output | 4 | One-hot row strobe shared by all ports |
| col_sense | input | 16 | Column lines, four per port, port p at bits 4p+3:4p |
| top_btn | input | 4 | Top side buttons, one per port, high when pressed |
| bot_btn | input | 4 | Bottom side buttons, one per port, high when pressed |
| irq_en | input | 2 | Enable mask: bit 0 key, bit 1 break |
| irq_ack | input | 2 | Acknowledge strobes: bit 0 key, bit 1 break |
| kbcode | output | 8 | Latched key code in bits 4:1 |
| keypad_val | output | 8 | Translated keypad value |
| shift_flag | output | 1 | Selected port's top button |
| irq_key | output | 1 | Keyboard interrupt request |
| irq_brk | output | 1 | Break interrupt request |
| trig_n | output | 4 | Per-port trigger, low while bottom button held |

## Verification
The assertions assume `sel_wr` is a single-cycle strobe. They also assume that column lines answer only to the row currently driven, which holds for a passive key matrix. The bench builds `col_sense` from its own key map and the design's `row_drive`, so the columns always stay consistent with the row being strobed. The bench holds key states steady across whole scans. Select writes are one cycle wide, and acknowledges are one-cycle pulses issued only after an interrupt has been observed.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
   localparam int ROWS   = 4;
   localparam int COLS   = 4;
   localparam int CODE_W = 4;

   typedef logic [CODE_W-1:0] keycode_t;

   // Folded code {row, col} to keypad value; code 0 is "no key"
   function automatic logic [7:0] code_to_pad(keycode_t c);
      logic [1:0] r;
      logic [1:0] k;
      logic [7:0] v;
      r = c[3:2];
      k = c[1:0];
      if (c == '0) begin
         v = 8'hFF;
      end else if (r == 2'd0) begin
         case (k)
            2'd1:    v = 8'h0B;
            2'd2:    v = 8'h00;
            default: v = 8'h0A;
         endcase
      end else if (k == 2'd0) begin
         v = 8'h0F - {6'd0, r};
      end else begin
         v = 8'd3 * {6'd0, 2'd3 - r} + {6'd0, 3'd4 - {1'b0, k}};
      end
      return v;
   endfunction
endpackage

// File: rtl/padmux_sync.sv
module padmux_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("padmux_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_chain
      logic [WIDTH-1:0] stage [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
         end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
         end
      end
      assign q = stage[STAGES-1];
   end
endmodule

// File: rtl/padmux_scan.sv
module padmux_scan
   import padmux_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int DWELL     = 4,
   parameter int SEL_W     = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      restart,
   input  logic [SEL_W-1:0]          sel,
   input  logic [NUM_PORTS*COLS-1:0] col_sync,
   output logic [ROWS-1:0]           row_drive,
   output keycode_t                  code_q,
   output logic                      key_evt
);
   localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL - 1);
   localparam logic [1:0] ROW_LAST = 2'(ROWS - 1);

   logic [CNT_W-1:0] cnt;
   logic [1:0]       row;
   logic             supp;
   keycode_t         best, last, cand, best_nx;
   logic [COLS-1:0]  port_cols [NUM_PORTS];
   logic [COLS-1:0]  cols;
   logic             sample, end_scan;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_cols
      assign port_cols[p] = col_sync[p*COLS +: COLS];
   end
   assign cols = port_cols[sel];

   for (genvar r = 0; r < ROWS; r++) begin : g_rows
      assign row_drive[r] = (row == 2'(r));
   end

   // lowest column in the current row wins; row 0 column 0 is empty
   always_comb begin
      cand = '0;
      for (int c = COLS - 1; c >= 0; c--) begin
         if (cols[c] && !(row == 2'd0 && c == 0)) cand = {row, 2'(c)};
      end
   end

   assign sample   = (cnt == CNT_LAST);
   assign end_scan = sample && (row == ROW_LAST);
   assign best_nx  = (best != '0) ? best : cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         row     <= '0;
         supp    <= 1'b0;
         best    <= '0;
         last    <= '0;
         code_q  <= '0;
         key_evt <= 1'b0;
      end else if (restart) begin
         cnt     <= '0;
         row     <= '0;
         supp    <= 1'b1;
         best    <= '0;
         key_evt <= 1'b0;
      end else begin
         key_evt <= 1'b0;
         if (sample) begin
            cnt <= '0;
            row <= row + 2'd1;
            if (end_scan) begin
               best <= '0;
               if (supp) begin
                  supp <= 1'b0;
                  last <= '0;
               end else begin
                  last <= best_nx;
                  if (best_nx != '0 && best_nx != last) begin
                     code_q  <= best_nx;
                     key_evt <= 1'b1;
                  end
               end
            end else begin
               best <= best_nx;
            end
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/padmux_irq.sv
module padmux_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] en,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[i] <= 1'b0;
         else        pend[i] <= (pend[i] & ~ack[i]) | (evt[i] & en[i]);
      end
   end
endmodule

// File: rtl/padmux_keyscan.sv
module padmux_keyscan
   import padmux_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int DWELL       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_PORTS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel_wr,
   input  logic [SEL_W-1:0]          sel_data,
   output logic [ROWS-1:0]           row_drive,
   input  logic [NUM_PORTS*COLS-1:0] col_sense,
   input  logic [NUM_PORTS-1:0]      top_btn,
   input  logic [NUM_PORTS-1:0]      bot_btn,
   input  logic [1:0]                irq_en,
   input  logic [1:0]                irq_ack,
   output logic [7:0]                kbcode,
   output logic [7:0]                keypad_val,
   output logic                      shift_flag,
   output logic                      irq_key,
   output logic                      irq_brk,
   output logic [NUM_PORTS-1:0]      trig_n
);
   if (NUM_PORTS < 2 || NUM_PORTS != (1 << SEL_W)) begin : g_bad_ports
      $error("padmux_keyscan: NUM_PORTS must be a power of two, at least 2");
   end
   if (DWELL <= SYNC_STAGES) begin : g_bad_dwell
      $error("padmux_keyscan: DWELL must exceed SYNC_STAGES");
   end
   if (ROWS * COLS != (1 << CODE_W)) begin : g_bad_matrix
      $error("padmux_keyscan: matrix size must match the code width");
   end

   logic [SEL_W-1:0]          sel_q;
   logic                      sel_moved;
   logic [NUM_PORTS*COLS-1:0] col_s;
   logic [NUM_PORTS-1:0]      top_s, bot_s;
   logic                      shift_q;
   logic                      brk_evt;
   logic                      key_evt;
   keycode_t                  code_q;
   logic [1:0]                pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         sel_moved <= 1'b0;
         shift_q   <= 1'b0;
      end else begin
         if (sel_wr) sel_q <= sel_data;
         sel_moved <= sel_wr;
         shift_q   <= shift_flag;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_sync
      padmux_sync #(.WIDTH(COLS + 2), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     ({bot_btn[p], top_btn[p], col_sense[p*COLS +: COLS]}),
         .q     ({bot_s[p], top_s[p], col_s[p*COLS +: COLS]})
      );
   end

   padmux_scan #(.NUM_PORTS(NUM_PORTS), .DWELL(DWELL), .SEL_W(SEL_W)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (sel_wr),
      .sel       (sel_q),
      .col_sync  (col_s),
      .row_drive (row_drive),
      .code_q    (code_q),
      .key_evt   (key_evt)
   );

   assign shift_flag = top_s[sel_q];
   assign brk_evt    = shift_flag & ~shift_q & ~sel_moved;

   padmux_irq #(.N(2)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   ({brk_evt, key_evt}),
      .en    (irq_en),
      .ack   (irq_ack),
      .pend  (pend)
   );

   assign irq_key    = pend[0];
   assign irq_brk    = pend[1];
   assign trig_n     = ~bot_s;
   assign kbcode     = {3'b000, code_q, 1'b0};
   assign keypad_val = code_to_pad(code_q);
endmodule

// File: rtl/padmux_keyscan_chk.sv
module padmux_keyscan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_wr,
   input logic [1:0] irq_en,
   input logic [1:0] irq_ack,
   input logic [3:0] row_drive,
   input logic [7:0] kbcode,
   input logic [7:0] keypad_val,
   input logic       shift_flag,
   input logic       irq_key,
   input logic       irq_brk
);
   // R10: exactly one row strobed at any time
   assert_row_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_drive) == 1);

   // R9: a select write puts the scan back on row 0
   assert_restart_row0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> row_drive == 4'b0001);

   // R8: pending key request held until acknowledged
   assert_key_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_key && !irq_ack[0]) |=> irq_key);

   // R8: pending break request held until acknowledged
   assert_brk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_brk && !irq_ack[1]) |=> irq_brk);

   // R6: key request only rises when enabled
   assert_key_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_key) |-> $past(irq_en[0]));

   // R5: break request only rises after an enabled shift press
   assert_brk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_brk) |-> ($past(irq_en[1]) && $past(shift_flag)));

   // R4: empty code reads as the no-key value
   assert_nokey_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kbcode == 8'h00) |-> (keypad_val == 8'hFF));
endmodule

bind padmux_keyscan padmux_keyscan_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_wr     (sel_wr),
   .irq_en     (irq_en),
   .irq_ack    (irq_ack),
   .row_drive  (row_drive),
   .kbcode     (kbcode),
   .keypad_val (keypad_val),
   .shift_flag (shift_flag),
   .irq_key    (irq_key),
   .irq_brk    (irq_brk)
);

// File: tb/padmux_keyscan_bench.sv
module padmux_keyscan_bench;
   localparam int NP = 4;
   localparam int DW = 4;
   localparam int SY = 2;
   localparam int SCAN = 4 * DW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_wr = 1'b0;
   logic [1:0]  sel_data = 2'd0;
   logic [3:0]  row_drive;
   logic [15:0] col_sense;
   logic [3:0]  top_btn = '0;
   logic [3:0]  bot_btn = '0;
   logic [1:0]  irq_en = 2'b11;
   logic [1:0]  irq_ack = 2'b00;
   logic [7:0]  kbcode, keypad_val;
   logic        shift_flag, irq_key, irq_brk;
   logic [3:0]  trig_n;
   logic [15:0] keys [NP];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   padmux_keyscan #(.NUM_PORTS(NP), .DWELL(DW), .SYNC_STAGES(SY)) u_padmux_keyscan (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
      .row_drive(row_drive), .col_sense(col_sense), .top_btn(top_btn),
      .bot_btn(bot_btn), .irq_en(irq_en), .irq_ack(irq_ack), .kbcode(kbcode),
      .keypad_val(keypad_val), .shift_flag(shift_flag), .irq_key(irq_key),
      .irq_brk(irq_brk), .trig_n(trig_n)
   );

   // passive key matrix per port
   always_comb begin
      col_sense = '0;
      for (int p = 0; p < NP; p++)
         for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
               if (row_drive[r] && keys[p][r*4+c]) col_sense[p*4+c] = 1'b1;
   end

   function automatic logic [7:0] pad_of(int code);
      case (code)
         0: return 8'hFF;   1: return 8'h0B;   2: return 8'h00;   3: return 8'h0A;
         4: return 8'h0E;   5: return 8'h09;   6: return 8'h08;   7: return 8'h07;
         8: return 8'h0D;   9: return 8'h06;  10: return 8'h05;  11: return 8'h04;
        12: return 8'h0C;  13: return 8'h03;  14: return 8'h02;  default: return 8'h01;
      endcase
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_sel, m_cnt, m_row, m_best, m_last, m_code;
   bit         m_supp, m_kevt, m_shq, m_moved, m_pk, m_pb;
   logic [15:0] hc [SY];
   logic [3:0]  ht [SY];
   logic [3:0]  hb [SY];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 0; m_cnt = 0; m_row = 0; m_best = 0; m_last = 0; m_code = 0;
         m_supp = 0; m_kevt = 0; m_shq = 0; m_moved = 0; m_pk = 0; m_pb = 0;
         for (int i = 0; i < SY; i++) begin hc[i] = '0; ht[i] = '0; hb[i] = '0; end
      end else begin
         bit sh, brk, kev_n;
         int cand, bn;
         logic [3:0] cols;
         sh  = ht[SY-1][m_sel];
         brk = sh && !m_shq && !m_moved;
         m_pb = (m_pb && !irq_ack[1]) || (brk && irq_en[1]);
         m_pk = (m_pk && !irq_ack[0]) || (m_kevt && irq_en[0]);
         m_shq = sh;
         m_moved = sel_wr;
         kev_n = 0;
         if (sel_wr) begin
            m_cnt = 0; m_row = 0; m_supp = 1; m_best = 0;
         end else if (m_cnt == DW - 1) begin
            cols = hc[SY-1][m_sel*4 +: 4];
            cand = 0;
            for (int c = 3; c >= 0; c--)
               if (cols[c] && !(m_row == 0 && c == 0)) cand = m_row * 4 + c;
            bn = (m_best != 0) ? m_best : cand;
            if (m_row == 3) begin
               m_best = 0;
               if (m_supp) begin
                  m_supp = 0; m_last = 0;
               end else begin
                  if (bn != 0 && bn != m_last) begin m_code = bn; kev_n = 1; end
                  m_last = bn;
               end
            end else m_best = bn;
            m_cnt = 0;
            m_row = (m_row + 1) % 4;
         end else m_cnt++;
         m_kevt = kev_n;
         if (sel_wr) m_sel = sel_data;
         for (int i = SY - 1; i > 0; i--) begin
            hc[i] = hc[i-1]; ht[i] = ht[i-1]; hb[i] = hb[i-1];
         end
         hc[0] = col_sense; ht[0] = top_btn; hb[0] = bot_btn;
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(row_drive == 4'(1 << m_row), "R10 row_drive", row_drive, 1 << m_row);
         check(kbcode == {3'b0, 4'(m_code), 1'b0}, "R3/R7 kbcode", kbcode, m_code << 1);
         check(keypad_val == pad_of(m_code), "R4 keypad_val", keypad_val, pad_of(m_code));
         check(shift_flag == ht[SY-1][m_sel], "R5 shift_flag", shift_flag, ht[SY-1][m_sel]);
         check(irq_key == m_pk, "R6 irq_key", irq_key, m_pk);
         check(irq_brk == m_pb, "R5 irq_brk", irq_brk, m_pb);
         check(trig_n == ~hb[SY-1], "R2 trig_n", trig_n, ~hb[SY-1]);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic select(int s);
      sel_data = 2'(s); sel_wr = 1'b1;
      cyc(1);
      sel_wr = 1'b0;
   endtask

   task automatic ack(int b);
      irq_ack[b] = 1'b1;
      cyc(1);
      irq_ack[b] = 1'b0;
   endtask

   task automatic release_all();
      for (int p = 0; p < NP; p++) keys[p] = '0;
      cyc(3 * SCAN);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) keys[p] = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R11 reset state
      check(kbcode == 8'h00, "R11 kbcode", kbcode, 0);
      check(keypad_val == 8'hFF, "R11 keypad_val", keypad_val, 8'hFF);
      check(!irq_key && !irq_brk, "R11 irqs", {irq_brk, irq_key}, 0);
      check(row_drive == 4'b0001 || row_drive == 4'b0010, "R11 row_drive", row_drive, 1);

      // R4 R3 R6: every key on port 0
      for (int k = 1; k < 16; k++) begin
         keys[0] = 16'(1) << k;
         cyc(3 * SCAN);
         check(kbcode == 8'(k << 1), "R3 code field", kbcode, k << 1);
         check(keypad_val == pad_of(k), "R4 translation", keypad_val, pad_of(k));
         check(irq_key, "R6 key irq", irq_key, 1);
         ack(0);
         release_all();
      end

      // R10: position row 0 column 0 is not a key
      keys[0] = 16'h0001;
      cyc(3 * SCAN);
      check(!irq_key, "R10 empty slot", irq_key, 0);
      release_all();

      // R10: lowest code wins
      keys[0] = (16'(1) << 6) | (16'(1) << 12);
      cyc(3 * SCAN);
      check(kbcode == 8'(6 << 1), "R10 priority", kbcode, 6 << 1);
      ack(0);

      // R7: holding does not re-raise; a new key does
      cyc(4 * SCAN);
      check(!irq_key, "R7 held key once", irq_key, 0);
      keys[0] = 16'(1) << 12;
      cyc(3 * SCAN);
      check(kbcode == 8'(12 << 1) && irq_key, "R7 new key", kbcode, 12 << 1);
      ack(0);
      release_all();

      // R8: masked event sets nothing, code still latches
      irq_en[0] = 1'b0;
      keys[0] = 16'(1) << 2;
      cyc(3 * SCAN);
      check(!irq_key, "R8 masked key irq", irq_key, 0);
      check(kbcode == 8'(2 << 1), "R8 code latched", kbcode, 2 << 1);
      irq_en[0] = 1'b1;
      cyc(SCAN);
      check(!irq_key, "R8 no late irq", irq_key, 0);
      release_all();

      // R1: each port routed by its select value
      for (int s = 1; s < NP; s++) begin
         select(s);
         keys[0] = 16'(1) << 15;
         keys[s] = 16'(1) << (4 + s);
         cyc(3 * SCAN);
         check(kbcode == 8'((4 + s) << 1), "R1 port route", kbcode, (4 + s) << 1);
         ack(0);
         top_btn = 4'(1) << s;
         cyc(SY + 1);
         check(shift_flag, "R1 shift route", shift_flag, 1);
         check(irq_brk, "R5 break irq", irq_brk, 1);
         ack(1);
         cyc(1);
         check(!irq_brk, "R8 break ack", irq_brk, 0);
         top_btn = 4'b0001;
         cyc(SY + 1);
         check(!shift_flag, "R1 unselected top", shift_flag, 0);
         top_btn = '0;
         release_all();
      end

      // R5: break masked
      irq_en[1] = 1'b0;
      top_btn = 4'b1000;
      cyc(SY + 2);
      check(shift_flag && !irq_brk, "R5 masked break", irq_brk, 0);
      top_btn = '0;
      irq_en[1] = 1'b1;
      cyc(SY + 1);

      // R9: select change discards the first scan
      keys[3] = 16'(1) << 7;
      cyc(3 * SCAN);
      ack(0);
      keys[0] = 16'(1) << 3;
      select(0);
      cyc(SCAN + 4);
      check(kbcode == 8'(7 << 1) && !irq_key, "R9 suppressed scan", kbcode, 7 << 1);
      cyc(SCAN + 4);
      check(kbcode == 8'(3 << 1) && irq_key, "R9 after suppress", kbcode, 3 << 1);
      ack(0);
      release_all();

      // R2: triggers independent of select
      bot_btn = 4'b0101;
      for (int s = 0; s < NP; s++) begin
         select(s);
         cyc(SY + 1);
         check(trig_n == 4'b1010, "R2 trigger", trig_n, 4'b1010);
      end
      bot_btn = '0;
      cyc(SY + 1);
      check(trig_n == 4'b1111, "R2 trigger release", trig_n, 4'b1111);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule